// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch Controller

This block is the slave-side instruction front end of a serial flash device. It watches the chip-select, serial-clock and serial-data-in pins, oversampling them with the core clock. It collects one 8-bit instruction per chip-select frame and acts on that instruction when chip select returns high. At the centre of the block is the write-enable latch. Only an enable instruction can set it. A disable instruction clears it, reset clears it, and the end of every modifying operation clears it.

The modifying instructions are page program, sector erase, block erase, chip erase and status-register write. A modifying instruction is passed to the memory engine only while the latch is set and no other operation is running. When one is passed, the block raises a one-cycle start strobe with a kind code and then waits for the engine's done pulse. The memory array, addressing and read paths sit outside this block, so the data-out enable never asserts. No data stream crosses the block's edge, so all pins are plain control and status signals.

Top module: `spi_wel_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `wel`, `busy` and `op_start` are 0.
- R2: A frame that clocks exactly 8 bits, MSB first on rising `sck`, with value 0x06 sets `wel` once chip select rises, provided `busy` is 0.
- R3: A frame of exactly 8 bits with value 0x04 clears `wel`, whether or not `busy` is set.
- R4: A frame whose bit count is not 8 (for example 7 or 9) leaves `wel` and `busy` unchanged and gives no `op_start`, whatever its value.
- R5: An 8-bit frame with value 0x02, 0x20, 0xD8, 0xC7 or 0x01 that arrives while `wel`=1 and `busy`=0 gives exactly one single-cycle `op_start` and sets `busy`. During that pulse `op_kind` is 1, 2, 3, 4 or 5 respectively.
- R6: A modifying frame that arrives while `wel`=0 gives no `op_start` and leaves `busy` at 0.
- R7: An `op_done` pulse while `busy`=1 clears both `busy` and `wel`.
- R8: While `busy`=1, an enable frame and all modifying frames have no effect and give no `op_start`.
- R9: `sdo_oe` stays 0 at all times, so the data output stays high impedance.
- R10: An 8-bit frame with any other value leaves `wel` and `busy` unchanged.
- R11: An `op_done` pulse while `busy`=0 leaves `wel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cs_n | input | 1 | Chip select, active low; frames one instruction |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| sdo_oe | output | 1 | Data-out driver enable, 0 means high impedance |
| op_start | output | 1 | One-cycle strobe that starts a modifying operation |
| op_kind | output | 3 | Kind of the operation in progress (1..5, 0 when idle) |
| op_done | input | 1 | One-cycle pulse from the engine when the operation finishes |
| wel | output | 1 | Write-enable latch state |
| busy | output | 1 | A modifying operation is in progress |

## Verification
A wrong latch state is seen directly on `wel` a few core clocks after chip select rises. Because the next modifying frame then either starts or does not start, the error also spreads into `op_start` and `busy` within one frame. A bit counter that is off by one shows up as an enable or disable frame that is taken at the wrong length, which is visible on `wel` after that frame. Bad gating shows up as an extra or missing `op_start` pulse in the same cycle the frame would have been taken. A lost clear shows up as `wel` still set after `op_done`.

// File: rtl/spi_wel_pkg.sv
package spi_wel_pkg;

  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OPC_WEN    = 8'h06;
  localparam logic [OP_W-1:0] OPC_WDIS   = 8'h04;
  localparam logic [OP_W-1:0] OPC_PAGE   = 8'h02;
  localparam logic [OP_W-1:0] OPC_SECTOR = 8'h20;
  localparam logic [OP_W-1:0] OPC_BLOCK  = 8'hD8;
  localparam logic [OP_W-1:0] OPC_CHIP   = 8'hC7;
  localparam logic [OP_W-1:0] OPC_STATUS = 8'h01;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_PAGE   = 3'd1,
    KIND_SECTOR = 3'd2,
    KIND_BLOCK  = 3'd3,
    KIND_CHIP   = 3'd4,
    KIND_STATUS = 3'd5
  } op_kind_e;

  // Map an opcode to its modifying-operation kind; KIND_NONE otherwise.
  function automatic op_kind_e kind_of(input logic [OP_W-1:0] opc);
    case (opc)
      OPC_PAGE:   return KIND_PAGE;
      OPC_SECTOR: return KIND_SECTOR;
      OPC_BLOCK:  return KIND_BLOCK;
      OPC_CHIP:   return KIND_CHIP;
      OPC_STATUS: return KIND_STATUS;
      default:    return KIND_NONE;
    endcase
  endfunction

endpackage

// File: rtl/spi_wel_sync.sv
// Multi-stage synchronizer for the serial pins, plus a one-cycle-delayed
// copy used for edge detection.
module spi_wel_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= RST_VAL;
    else        prev_o <= chain[STAGES-1];
  end

  assign cur_o = chain[STAGES-1];

endmodule

// File: rtl/spi_wel_frame.sv
// Collects the bits of one chip-select frame and reports the opcode when
// chip select rises, flagging whether exactly OP_W bits were clocked.
module spi_wel_frame #(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n_cur,
  input  logic            cs_n_prev,
  input  logic            sck_cur,
  input  logic            sck_prev,
  input  logic            sdi_cur,
  output logic            frame_ok,
  output logic [OP_W-1:0] frame_op
);

  localparam int CNT_MAX = OP_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [OP_W-1:0]  shreg;
  logic [CNT_W-1:0] bitcnt;
  logic             cs_fall, cs_rise, sck_rise;

  assign cs_fall  = cs_n_prev & ~cs_n_cur;
  assign cs_rise  = ~cs_n_prev & cs_n_cur;
  assign sck_rise = ~sck_prev & sck_cur & ~cs_n_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (cs_fall) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[OP_W-2:0], sdi_cur};
      if (bitcnt != CNT_W'(CNT_MAX)) bitcnt <= bitcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_ok <= 1'b0;
      frame_op <= '0;
    end else begin
      frame_ok <= cs_rise && (bitcnt == CNT_W'(OP_W));
      frame_op <= shreg;
    end
  end

endmodule

// File: rtl/spi_wel_latch.sv
// Write-enable latch, modifying-command gating and the engine handshake.
module spi_wel_latch
  import spi_wel_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_ok,
  input  logic [OP_W-1:0] frame_op,
  input  logic            op_done,
  output logic            wel,
  output logic            busy,
  output logic            op_start,
  output op_kind_e        op_kind
);

  op_kind_e dec_kind;
  logic     is_wen, is_wdis, is_mod;

  assign dec_kind = kind_of(frame_op);
  assign is_wen   = frame_ok && (frame_op == OPC_WEN);
  assign is_wdis  = frame_ok && (frame_op == OPC_WDIS);
  assign is_mod   = frame_ok && (dec_kind != KIND_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel      <= 1'b0;
      busy     <= 1'b0;
      op_start <= 1'b0;
      op_kind  <= KIND_NONE;
    end else begin
      op_start <= 1'b0;
      // Completion of the running operation clears the latch.
      if (busy && op_done) begin
        busy    <= 1'b0;
        wel     <= 1'b0;
        op_kind <= KIND_NONE;
      end
      if (is_wdis) begin
        wel <= 1'b0;
      end else if (is_wen && !busy) begin
        wel <= 1'b1;
      end else if (is_mod && wel && !busy) begin
        busy     <= 1'b1;
        op_start <= 1'b1;
        op_kind  <= dec_kind;
      end
    end
  end

endmodule

// File: rtl/spi_wel_ctrl.sv
module spi_wel_ctrl
  import spi_wel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  output logic       sdo_oe,
  output logic       op_start,
  output logic [2:0] op_kind,
  input  logic       op_done,
  output logic       wel,
  output logic       busy
);

  localparam int PIN_N = 3;
  localparam int IX_CS = 2;
  localparam int IX_CK = 1;
  localparam int IX_DI = 0;
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b100;

  logic [PIN_N-1:0] pin_cur, pin_prev;
  logic             frame_ok;
  logic [OP_W-1:0]  frame_op;
  op_kind_e         kind_q;

  spi_wel_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({cs_n, sck, sdi}),
    .cur_o (pin_cur),
    .prev_o(pin_prev)
  );

  spi_wel_frame #(.OP_W(OP_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_cur (pin_cur[IX_CS]),
    .cs_n_prev(pin_prev[IX_CS]),
    .sck_cur  (pin_cur[IX_CK]),
    .sck_prev (pin_prev[IX_CK]),
    .sdi_cur  (pin_cur[IX_DI]),
    .frame_ok (frame_ok),
    .frame_op (frame_op)
  );

  spi_wel_latch #(.OP_W(OP_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_ok(frame_ok),
    .frame_op(frame_op),
    .op_done (op_done),
    .wel     (wel),
    .busy    (busy),
    .op_start(op_start),
    .op_kind (kind_q)
  );

  assign op_kind = kind_q;
  // No read path lives here: the output driver is never enabled.
  assign sdo_oe  = 1'b0;

endmodule

// File: rtl/spi_wel_ctrl_chk.sv
module spi_wel_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wel,
  input logic       busy,
  input logic       op_start,
  input logic       op_done,
  input logic [2:0] op_kind
);

  AST_START_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> wel);  // R5

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !$past(busy));  // R8

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);  // R5

  AST_BUSY_ONLY_BY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> op_start);  // R6

  AST_START_KIND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (op_kind >= 3'd1 && op_kind <= 3'd5));  // R5

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done) |=> (!wel && !busy));  // R7

  AST_SET_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy));  // R8

endmodule

bind spi_wel_ctrl spi_wel_ctrl_chk u_chk (.*);

// File: tb/tb_spi_wel_ctrl.sv
module tb_spi_wel_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       sdi = 1'b0;
  logic       op_done = 1'b0;
  logic       sdo_oe, op_start, wel, busy;
  logic [2:0] op_kind;

  int n_cmp = 0;
  int n_bad = 0;
  int start_cnt = 0;
  int last_kind = 0;
  int oe_seen = 0;

  // Reference model state
  bit m_wel  = 1'b0;
  bit m_busy = 1'b0;
  int m_starts = 0;
  int m_kind = 0;

  always #5 clk = ~clk;

  spi_wel_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo_oe(sdo_oe), .op_start(op_start), .op_kind(op_kind),
    .op_done(op_done), .wel(wel), .busy(busy)
  );

  always @(negedge clk) begin
    if (op_start) begin
      start_cnt <= start_cnt + 1;
      last_kind <= int'(op_kind);
    end
    if (sdo_oe) oe_seen <= oe_seen + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int kind_ref(input logic [7:0] op);
    case (op)
      8'h02: return 1;
      8'h20: return 2;
      8'hD8: return 3;
      8'hC7: return 4;
      8'h01: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic void model_frame(input logic [7:0] op, input int nb);
    if (nb != 8) return;
    if (op == 8'h04) m_wel = 1'b0;
    else if (op == 8'h06) begin
      if (!m_busy) m_wel = 1'b1;
    end else if (kind_ref(op) != 0 && m_wel && !m_busy) begin
      m_busy = 1'b1;
      m_starts++;
      m_kind = kind_ref(op);
    end
  endfunction

  function automatic void model_done();
    if (m_busy) begin
      m_busy = 1'b0;
      m_wel  = 1'b0;
    end
  endfunction

  task automatic send(input logic [7:0] op, input int nb);
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 8) ? op[7-i] : 1'b0;
      sck = 1'b0;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
    end
    sck = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    model_frame(op, nb);
  endtask

  task automatic pulse_done();
    @(negedge clk) op_done = 1'b1;
    @(negedge clk) op_done = 1'b0;
    repeat (3) @(negedge clk);
    model_done();
  endtask

  task automatic compare_all(input string tag);
    check({tag, " wel"},    int'(wel),  int'(m_wel));
    check({tag, " busy"},   int'(busy), int'(m_busy));
    check({tag, " starts"}, start_cnt,  m_starts);
    if (m_starts > 0) check({tag, " kind"}, last_kind, m_kind);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] pick [8];
    pick = '{8'h06, 8'h04, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01, 8'h00};
    void'($urandom(32'd4711));

    repeat (4) @(negedge clk);
    check("R1 wel in reset", int'(wel), 0);
    check("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 wel after reset", int'(wel), 0);
    check("R1 start after reset", start_cnt, 0);
    check("R9 sdo_oe idle", int'(sdo_oe), 0);

    send(8'h06, 8);  check("R2 enable sets", int'(wel), 1);
    send(8'h04, 8);  check("R3 disable clears", int'(wel), 0);
    send(8'h06, 7);  check("R4 7-bit enable", int'(wel), 0);
    send(8'h06, 9);  check("R4 9-bit enable", int'(wel), 0);
    send(8'h02, 8);  check("R6 program no latch", start_cnt, 0);
    check("R6 busy stays low", int'(busy), 0);
    send(8'h06, 8);
    send(8'h04, 7);  check("R4 7-bit disable keeps", int'(wel), 1);
    pulse_done();    check("R11 idle done keeps", int'(wel), 1);
    send(8'hAB, 8);  check("R10 unknown keeps", int'(wel), 1);
    compare_all("R10");
    send(8'hC7, 8);  check("R5 chip start", start_cnt, 1);
    check("R5 chip kind", last_kind, 4);
    check("R5 busy set", int'(busy), 1);
    send(8'h04, 8);  check("R3 disable while busy", int'(wel), 0);
    send(8'h06, 8);  check("R8 enable while busy", int'(wel), 0);
    send(8'h20, 8);  check("R8 erase while busy", start_cnt, 1);
    pulse_done();    check("R7 done clears busy", int'(busy), 0);
    send(8'h06, 8);
    send(8'h01, 8);  check("R5 status kind", last_kind, 5);
    send(8'h06, 8);  check("R8 enable ignored busy", int'(busy), 1);
    pulse_done();    check("R7 done clears wel", int'(wel), 0);
    compare_all("R7");

    for (int it = 0; it < 250; it++) begin
      int r;
      int nb;
      logic [7:0] op;
      r  = int'($urandom_range(0, 9));
      op = (r < 7) ? pick[r] : 8'($urandom());
      nb = ($urandom_range(0, 7) == 0) ? int'($urandom_range(6, 10)) : 8;
      if ($urandom_range(0, 4) == 0) pulse_done();
      send(op, nb);
      compare_all(nb != 8 ? "R4 random" : "R5 random");
    end
    check("R9 sdo_oe never set", oe_seen, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule